// File: doc/BRIEF.md
# Bus Region Decoder with Fallback Responder

This block is the single central address decoder for a shared high-speed on-chip bus. It looks only at the top few bits of the transfer address and compares them with a small table of region tags. It then raises exactly one slave select line. Ignoring the low address bits keeps the comparators narrow, which saves area and switching power. An address whose top bits match no tag is routed to a built-in fallback responder, a virtual slave that exists only to answer on the bus.

Some slaves are allowed to postpone a transfer with a SPLIT response. A SPLIT is not allowed while the master holds the bus locked. If a locked transfer would reach one of these slaves, the decoder does not select it and routes the transfer to the fallback responder instead. The master then gets an ERROR and is never left waiting on a split that cannot complete.

The fallback responder answers idle and busy transfers with OKAY and no wait state. It answers active transfers with the standard two-cycle ERROR response. The response multiplexer and the real slaves sit outside this block.

Top module: `ahb_region_decoder`

## Requirements
- R1: In every cycle exactly one of the bits {`selVec`, `dfltSel`} is high.
- R2: Slave i is selected when `haddr[31:28]` equals its region tag and it is not blocked by a lock. The bits `haddr[27:0]` have no effect on the selection. The default tags for slaves 0..7 are 0x0, 0x1, 0x2, 0x4, 0x6, 0x8, 0xA and 0xC.
- R3: When `hmastlock` is high and the address hits a slave whose bit is set in `SPLIT_MASK`, that slave is not selected and `dfltSel` is high instead. The default mask is 8'b0010_0100, which marks slaves 2 and 5.
- R4: An address whose top four bits match no tag raises `dfltSel`. With the default tags this applies to 0x3, 0x5, 0x7, 0x9, 0xB, 0xD, 0xE and 0xF.
- R5: If the fallback responder is selected with `hready` high and `htrans` is IDLE (2'b00) or BUSY (2'b01), then in the next cycle `dfltReadyOut` is 1 and `dfltResp` is OKAY (2'b00).
- R6: If the fallback responder is selected with `hready` high and `htrans` is NONSEQ (2'b10) or SEQ (2'b11), the response runs over two cycles. In the next cycle `dfltReadyOut` is 0 and `dfltResp` is ERROR (2'b01). In the cycle after that `dfltReadyOut` is 1 and `dfltResp` is still ERROR. The response then returns to OKAY unless a new erroring transfer was sampled in that second cycle.
- R7: While `hready` is low, no address phase is sampled. An active transfer to an unmapped address presented then leaves the response at ready OKAY.
- R8: After reset `dfltReadyOut` is 1 and `dfltResp` is OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haddr | input | 32 | Address of the current address phase |
| htrans | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| hmastlock | input | 1 | The current transfer is part of a locked sequence |
| hready | input | 1 | Bus-wide ready; an address phase is taken when it is high |
| selVec | output | 8 | One-hot select for the mapped slaves |
| dfltSel | output | 1 | Select for the fallback responder |
| dfltReadyOut | output | 1 | Ready output of the fallback responder |
| dfltResp | output | 2 | Response of the fallback responder: OKAY 00, ERROR 01 |

## Verification
The hardest case to reach is a locked active transfer to a split-capable region. Here the decoder drops a select it would otherwise give and must also start the two-cycle error. The bench sweeps all sixteen tags with the lock both off and on, and uses NONSEQ and SEQ, so this case comes up for both marked slaves. It also starts a new erroring transfer in the second error cycle, checks that the wait cycle begins again, and presents an erroring transfer while `hready` is low.

// File: rtl/ahbdec_pkg.sv
package ahbdec_pkg;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;

  typedef enum logic [1:0] {
    DS_IDLE     = 2'd0,
    DS_ERR_WAIT = 2'd1,
    DS_ERR_DONE = 2'd2
  } dsState_e;

  typedef struct packed {
    logic loadOkay;
    logic loadErrWait;
    logic loadErrDone;
  } rspStrobe_t;
endpackage

// File: rtl/ahbdec_datapath.sv
module ahbdec_datapath
  import ahbdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 4,
  parameter int NUM_SLV = 8,
  parameter logic [NUM_SLV*TAG_W-1:0] REGION_TAGS = '0,
  parameter logic [NUM_SLV-1:0] SPLIT_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic               hmastlock,
  input  rspStrobe_t         strobe,
  output logic [NUM_SLV-1:0] selVec,
  output logic               dfltSel,
  output logic               readyOut,
  output logic [1:0]         resp
);
  localparam int TAG_LSB = ADDR_W - TAG_W;

  logic [TAG_W-1:0]   addrTag;
  logic [NUM_SLV-1:0] hitVec;
  logic [NUM_SLV-1:0] blockVec;

  assign addrTag = haddr[ADDR_W-1:TAG_LSB];

  // One narrow comparator per region; a lock blocks regions that may split.
  for (genvar i = 0; i < NUM_SLV; i++) begin : g_region
    assign hitVec[i]   = (addrTag == REGION_TAGS[i*TAG_W +: TAG_W]);
    assign blockVec[i] = hmastlock & SPLIT_MASK[i];
  end

  assign selVec  = hitVec & ~blockVec;
  assign dfltSel = ~|selVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyOut <= 1'b1;
      resp     <= RESP_OKAY;
    end else if (strobe.loadErrWait) begin
      readyOut <= 1'b0;
      resp     <= RESP_ERROR;
    end else if (strobe.loadErrDone) begin
      readyOut <= 1'b1;
      resp     <= RESP_ERROR;
    end else if (strobe.loadOkay) begin
      readyOut <= 1'b1;
      resp     <= RESP_OKAY;
    end
  end
endmodule

// File: rtl/ahbdec_control.sv
module ahbdec_control
  import ahbdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hready,
  input  logic [1:0] htrans,
  input  logic       dfltSel,
  output rspStrobe_t strobe
);
  dsState_e state, stateNext;
  logic startErr;

  // An active transfer (NONSEQ/SEQ) taken by the fallback responder.
  assign startErr = hready & dfltSel & htrans[1];

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      DS_ERR_WAIT: begin
        stateNext          = DS_ERR_DONE;
        strobe.loadErrDone = 1'b1;
      end
      default: begin
        if (startErr) begin
          stateNext          = DS_ERR_WAIT;
          strobe.loadErrWait = 1'b1;
        end else begin
          stateNext       = DS_IDLE;
          strobe.loadOkay = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= DS_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/ahb_region_decoder.sv
module ahb_region_decoder
  import ahbdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 4,
  parameter int NUM_SLV = 8,
  parameter logic [NUM_SLV*TAG_W-1:0] REGION_TAGS =
    {4'hC, 4'hA, 4'h8, 4'h6, 4'h4, 4'h2, 4'h1, 4'h0},
  parameter logic [NUM_SLV-1:0] SPLIT_MASK = 8'b0010_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic               hmastlock,
  input  logic               hready,
  output logic [NUM_SLV-1:0] selVec,
  output logic               dfltSel,
  output logic               dfltReadyOut,
  output logic [1:0]         dfltResp
);
  rspStrobe_t strobe;

  ahbdec_datapath #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NUM_SLV(NUM_SLV),
    .REGION_TAGS(REGION_TAGS), .SPLIT_MASK(SPLIT_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .haddr(haddr), .hmastlock(hmastlock),
    .strobe(strobe), .selVec(selVec), .dfltSel(dfltSel),
    .readyOut(dfltReadyOut), .resp(dfltResp)
  );

  ahbdec_control u_ctl (
    .clk(clk), .rstN(rstN), .hready(hready), .htrans(htrans),
    .dfltSel(dfltSel), .strobe(strobe)
  );
endmodule

// File: rtl/ahbdec_checker.sv
module ahbdec_checker #(
  parameter int NUM_SLV = 8,
  parameter logic [NUM_SLV-1:0] SPLIT_MASK = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         htrans,
  input logic               hmastlock,
  input logic               hready,
  input logic [NUM_SLV-1:0] selVec,
  input logic               dfltSel,
  input logic               dfltReadyOut,
  input logic [1:0]         dfltResp
);
  // R1: exactly one select
  p_one_select_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({selVec, dfltSel}));

  // R3: a locked transfer never selects a split-capable slave
  p_lock_no_split_r3: assert property (@(posedge clk) disable iff (!rstN)
    hmastlock |-> ((selVec & SPLIT_MASK) == '0));

  // R5: idle/busy to the fallback responder is answered OKAY with no wait
  p_idle_okay_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hready && dfltSel && !htrans[1]) |=> (dfltReadyOut && dfltResp == 2'b00));

  // R6: first error cycle
  p_err_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hready && dfltSel && htrans[1]) |=> (!dfltReadyOut && dfltResp == 2'b01));

  // R6: second error cycle follows a wait cycle
  p_err_second_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dfltReadyOut |=> (dfltReadyOut && dfltResp == 2'b01));

  // R7: no address phase is taken while hready is low
  p_hold_okay_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!hready && dfltReadyOut && dfltResp == 2'b00) |=>
      (dfltReadyOut && dfltResp == 2'b00));
endmodule

bind ahb_region_decoder ahbdec_checker #(
  .NUM_SLV(NUM_SLV), .SPLIT_MASK(SPLIT_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .htrans(htrans), .hmastlock(hmastlock),
  .hready(hready), .selVec(selVec), .dfltSel(dfltSel),
  .dfltReadyOut(dfltReadyOut), .dfltResp(dfltResp)
);

// File: tb/tb_ahb_region_decoder.sv
`timescale 1ns/1ps
module tb_ahb_region_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hmastlock = 1'b0;
  logic        hready = 1'b1;
  logic [7:0]  selVec;
  logic        dfltSel;
  logic        dfltReadyOut;
  logic [1:0]  dfltResp;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // Tags of slaves 0..7 and the split-capable set, as stated in R2/R3.
  int tagOf [8] = '{0, 1, 2, 4, 6, 8, 10, 12};
  logic [7:0] splitMask = 8'b0010_0100;

  always #4 clk = ~clk;

  ahb_region_decoder dut (
    .clk(clk), .rstN(rstN), .haddr(haddr), .htrans(htrans),
    .hmastlock(hmastlock), .hready(hready), .selVec(selVec),
    .dfltSel(dfltSel), .dfltReadyOut(dfltReadyOut), .dfltResp(dfltResp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expSel(input int tag, input bit lock);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++)
      if (tagOf[i] == tag && !(lock && splitMask[i])) v[i] = 1'b1;
    return {v, (v == '0)};
  endfunction

  function automatic string reqOf(input int tag, input bit lock);
    string r = "R4";
    for (int i = 0; i < 8; i++)
      if (tagOf[i] == tag) r = (lock && splitMask[i]) ? "R3" : "R2";
    return r;
  endfunction

  task automatic chkResp(input logic rdy, input logic [1:0] rsp, input string req);
    chk(dfltReadyOut === rdy && dfltResp === rsp, req,
        {29'd0, dfltReadyOut, dfltResp}, {29'd0, rdy, rsp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [27:0] lowPat [3] = '{28'h0000000, 28'hFFFFFFF, 28'h5A5A5A5};
    repeat (3) @(negedge clk);
    chkResp(1'b1, 2'b00, "R8 reset");
    rstN = 1'b1;
    @(negedge clk);

    // Decode sweep: all tags, lock off/on, three low-bit patterns, idle/busy.
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < 2; l++) begin
        for (int p = 0; p < 3; p++) begin
          logic [8:0] e;
          haddr = {t[3:0], lowPat[p]};
          hmastlock = l[0];
          htrans = (p == 1) ? 2'b01 : 2'b00;
          hready = 1'b1;
          #1;
          e = expSel(t, l[0]);
          chk({selVec, dfltSel} === e, reqOf(t, l[0]), {23'd0, selVec, dfltSel}, {23'd0, e});
          chk($countones({selVec, dfltSel}) == 1, "R1", {23'd0, selVec, dfltSel}, 32'd1);
          @(negedge clk);
          chkResp(1'b1, 2'b00, "R5 idle/busy okay");
        end
      end
    end

    // Active transfers: two-cycle error on default, okay on a real slave.
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < 2; l++) begin
        logic [8:0] e;
        haddr = {t[3:0], 28'h0123456};
        hmastlock = l[0];
        htrans = l[0] ? 2'b11 : 2'b10;
        hready = 1'b1;
        #1;
        e = expSel(t, l[0]);
        @(negedge clk);
        if (e[0]) begin
          chkResp(1'b0, 2'b01, "R6 first error cycle");
          hready = 1'b0;
          htrans = 2'b00;
          @(negedge clk);
          chkResp(1'b1, 2'b01, "R6 second error cycle");
          hready = 1'b1;
          @(negedge clk);
          chkResp(1'b1, 2'b00, "R6 back to okay");
        end else begin
          chkResp(1'b1, 2'b00, "R2 mapped slave leaves default idle");
        end
      end
    end

    // R7: an active unmapped transfer with hready low is not taken.
    hmastlock = 1'b0;
    haddr = 32'h3000_0000;
    htrans = 2'b10;
    hready = 1'b0;
    @(negedge clk);
    chkResp(1'b1, 2'b00, "R7 hready low ignored");
    @(negedge clk);
    chkResp(1'b1, 2'b00, "R7 hready low ignored again");

    // R6: back-to-back error started in the second error cycle.
    hready = 1'b1;
    @(negedge clk);
    chkResp(1'b0, 2'b01, "R6 first error cycle");
    hready = 1'b0;
    @(negedge clk);
    chkResp(1'b1, 2'b01, "R6 second error cycle");
    hready = 1'b1;
    haddr = 32'h5000_0040;
    htrans = 2'b11;
    @(negedge clk);
    chkResp(1'b0, 2'b01, "R6 back-to-back restart");
    hready = 1'b0;
    htrans = 2'b00;
    @(negedge clk);
    chkResp(1'b1, 2'b01, "R6 back-to-back second cycle");
    hready = 1'b1;
    @(negedge clk);
    chkResp(1'b1, 2'b00, "R6 okay after back-to-back");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule